// File: doc/BRIEF.md
# Vector Add-with-Carry Element Unit

This sequential unit computes integer add-with-carry and subtract-with-borrow across one vector register group, one element per clock. A start pulse captures the operands, which are two flat source vectors or one vector plus a scalar. It also captures a mask vector that holds one carry or borrow bit per element, the active length, the maximum length, the element width, the mask field stride and the operation. The unit then walks elements 0 to vl-1 and writes each result into its destination register.

When the active elements are done, one more cycle clears every destination byte between the end of the active region and the end of the vlmax region. The cycle after that, done is raised for one cycle. Destination bytes beyond the vlmax region keep the old destination value presented with the start pulse. The destination is read from `vd_o`.

Top module: `vadc_unit`

## Requirements
- R1: With `sub_i`=0, element i of the result is vs2[i] + op1[i] + c[i], truncated to the element width.
- R2: With `sub_i`=1, element i of the result is vs2[i] - op1[i] - c[i], truncated to the element width. A borrow out of the top bit is discarded.
- R3: `sew_i` encodes the element width as 0=8, 1=16, 2=32 and 3=64 bits. Element i occupies bytes i*esz to i*esz+esz-1 of each flat bus, least significant byte first, where esz is the width in bytes.
- R4: The carry for element i is bit i*`mlen_i` of `mask_i`. No other mask bit has any effect. When i*`mlen_i` is not below the mask width, the carry is 0.
- R5: With `scalar_sel_i`=1, op1 is `scalar_i` sign-extended from XLEN bits to 64 bits and then truncated to the element width. Otherwise op1 is element i of `vs1_i`.
- R6: Bytes from vl*esz up to vlmax*esz of the result are zero.
- R7: Bytes at or above vlmax*esz of the result equal the corresponding bytes of `vd_i` captured at start.
- R8: With vl=0, no element is computed, the whole vlmax region is zeroed, and done follows as for any other vl.
- R9: After reset, `vd_o` is zero and `busy_o` and `done_o` are low. Counting the start edge as edge 0, `done_o` is high exactly after edge vl+1, for exactly one cycle, and `vd_o` then holds the final result.
- R10: All inputs are captured on the accepted start. A start while `busy_o` is high is ignored. Outside an operation, `vd_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| scalar_sel_i | input | 1 | 1 = take op1 from scalar_i |
| sew_i | input | 2 | Element width code |
| vl_i | input | IDX_W | Active element count |
| vlmax_i | input | IDX_W | Element count of the register group |
| mlen_i | input | 7 | Mask field stride in bits (1..64) |
| vs1_i | input | VLEN | First vector operand |
| vs2_i | input | VLEN | Second vector operand (minuend) |
| scalar_i | input | XLEN | Scalar operand |
| mask_i | input | VLEN | Carry/borrow mask vector |
| vd_i | input | VLEN | Old destination contents |
| busy_o | output | 1 | Operation in progress (including done cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| vd_o | output | VLEN | Destination vector |

## Verification
Directed cases force carry wrap at 0xFF+0+1 and borrow wrap at 0-0-1. A mask is built whose only set bits lie between the stride points, so the carry position is separated from neighbouring bits. A negative 32-bit scalar at 64-bit width shows whether sign extension happens before truncation. Short vl against long vlmax, with an all-ones old destination, separates the active, tail and preserved byte regions. Separate cases cover vl=0 and a start pulse with altered operands during a run. Seeded random runs mix all widths, strides, lengths and both operations, and each result is compared against a bench model. Every run also checks the done latency and the pulse width.

// File: rtl/vadc_pkg.sv
package vadc_pkg;
  typedef enum logic [1:0] {SEW8 = 2'd0, SEW16 = 2'd1, SEW32 = 2'd2, SEW64 = 2'd3} sew_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL, ST_FIN} state_e;

  function automatic logic [63:0] sew_mask(sew_e s);
    case (s)
      SEW8:    sew_mask = 64'h0000_0000_0000_00ff;
      SEW16:   sew_mask = 64'h0000_0000_0000_ffff;
      SEW32:   sew_mask = 64'h0000_0000_ffff_ffff;
      default: sew_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/vadc_carry_pick.sv
module vadc_carry_pick #(
  parameter int VLEN  = 256,
  parameter int IDX_W = 6
) (
  input  logic [VLEN-1:0]  mask_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [6:0]       mlen_i,
  output logic             carry_o
);
  localparam int POS_W = IDX_W + 7;
  localparam int SEL_W = $clog2(VLEN);

  logic [POS_W-1:0] pos;
  assign pos = POS_W'(idx_i) * POS_W'(mlen_i);
  // fields past the mask width give no carry
  assign carry_o = (pos < POS_W'(VLEN)) ? mask_i[pos[SEL_W-1:0]] : 1'b0;
endmodule

// File: rtl/vadc_elem_alu.sv
module vadc_elem_alu
  import vadc_pkg::*;
(
  input  sew_e        sew_i,
  input  logic        sub_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic        c_i,
  output logic [63:0] res_o
);
  logic [63:0] raw;
  assign raw   = sub_i ? (a_i - b_i - 64'(c_i)) : (a_i + b_i + 64'(c_i));
  assign res_o = raw & sew_mask(sew_i);
endmodule

// File: rtl/vadc_ctrl.sv
module vadc_ctrl
  import vadc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] vl_i,
  output logic             accept_o,
  output logic             run_o,
  output logic             tail_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] vl_o
);
  state_e           state_q;
  logic [IDX_W-1:0] idx_q, vl_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign run_o    = state_q == ST_RUN;
  assign tail_o   = state_q == ST_TAIL;
  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = state_q == ST_FIN;
  assign idx_o    = idx_q;
  assign vl_o     = vl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          vl_q    <= vl_i;
          idx_q   <= '0;
          state_q <= (vl_i == '0) ? ST_TAIL : ST_RUN;
        end
        ST_RUN: begin
          if (idx_q == vl_q - IDX_W'(1)) state_q <= ST_TAIL;
          else                           idx_q   <= idx_q + IDX_W'(1);
        end
        ST_TAIL: state_q <= ST_FIN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_IDX_BELOW_VL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (idx_q < vl_q)); // R6
  AST_ZERO_VL_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && vl_i == '0) |=> tail_o); // R8
  AST_VL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(vl_q))); // R10
endmodule

// File: rtl/vadc_unit.sv
module vadc_unit
  import vadc_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int XLEN  = 32,
  parameter int NB    = VLEN / 8,
  parameter int IDX_W = $clog2(NB + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic             scalar_sel_i,
  input  logic [1:0]       sew_i,
  input  logic [IDX_W-1:0] vl_i,
  input  logic [IDX_W-1:0] vlmax_i,
  input  logic [6:0]       mlen_i,
  input  logic [VLEN-1:0]  vs1_i,
  input  logic [VLEN-1:0]  vs2_i,
  input  logic [XLEN-1:0]  scalar_i,
  input  logic [VLEN-1:0]  mask_i,
  input  logic [VLEN-1:0]  vd_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [VLEN-1:0]  vd_o
);
  localparam int BSH_W = IDX_W + 6;

  logic             accept, run, tail, carry;
  logic [IDX_W-1:0] idx, vl_q;
  logic             sub_q, scal_q;
  sew_e             sew_q;
  logic [IDX_W-1:0] vlmax_q;
  logic [6:0]       mlen_q;
  logic [VLEN-1:0]  vs1_q, vs2_q, mask_q, vd_q, vd_d;
  logic [XLEN-1:0]  scalar_q;
  logic [BSH_W-1:0] bit_sh;
  logic [VLEN-1:0]  vs1_sh, vs2_sh;
  logic [63:0]      op_a, op_b, scal_ext, res;
  logic [2:0]       lane_msk;

  vadc_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .vl_i,
    .accept_o(accept), .run_o(run), .tail_o(tail),
    .busy_o, .done_o, .idx_o(idx), .vl_o(vl_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= 1'b0; scal_q <= 1'b0; sew_q <= SEW8;
      vlmax_q <= '0; mlen_q <= '0; scalar_q <= '0;
      vs1_q <= '0; vs2_q <= '0; mask_q <= '0;
    end else if (accept) begin
      sub_q <= sub_i; scal_q <= scalar_sel_i; sew_q <= sew_e'(sew_i);
      vlmax_q <= vlmax_i; mlen_q <= mlen_i; scalar_q <= scalar_i;
      vs1_q <= vs1_i; vs2_q <= vs2_i; mask_q <= mask_i;
    end
  end

  // element fetch: byte offset idx<<sew, scaled to bits
  assign bit_sh   = BSH_W'(idx) << (BSH_W'(sew_q) + BSH_W'(3));
  assign vs1_sh   = vs1_q >> bit_sh;
  assign vs2_sh   = vs2_q >> bit_sh;
  assign scal_ext = {{(64-XLEN){scalar_q[XLEN-1]}}, scalar_q};
  assign op_a     = vs2_sh[63:0];
  assign op_b     = scal_q ? scal_ext : vs1_sh[63:0];
  assign lane_msk = 3'((4'd1 << sew_q) - 4'd1);

  vadc_carry_pick #(.VLEN(VLEN), .IDX_W(IDX_W)) i_carry (
    .mask_i(mask_q), .idx_i(idx), .mlen_i(mlen_q), .carry_o(carry)
  );

  vadc_elem_alu i_alu (
    .sew_i(sew_q), .sub_i(sub_q), .a_i(op_a), .b_i(op_b), .c_i(carry), .res_o(res)
  );

  always_comb begin
    vd_d = accept ? vd_i : vd_q;
    for (int b = 0; b < NB; b++) begin
      logic [IDX_W-1:0] eidx;
      logic [2:0]       lane;
      eidx = IDX_W'(b) >> sew_q;
      lane = 3'(b) & lane_msk;
      if (run && eidx == idx)
        vd_d[b*8 +: 8] = res[{lane, 3'b000} +: 8];
      if (tail && eidx >= vl_q && eidx < vlmax_q)
        vd_d[b*8 +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vd_q <= '0;
    else         vd_q <= vd_d;
  end

  assign vd_o = vd_q;

  AST_VD_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(vd_o)); // R10
endmodule

// File: tb/test_vadc_unit.sv
module test_vadc_unit;
  localparam int VLEN  = 256;
  localparam int XLEN  = 32;
  localparam int NB    = VLEN / 8;
  localparam int IDX_W = $clog2(NB + 1);

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             start = 1'b0, sub = 1'b0, ssel = 1'b0;
  logic [1:0]       sew = '0;
  logic [IDX_W-1:0] vl = '0, vlmax = '0;
  logic [6:0]       mlen = 7'd1;
  logic [VLEN-1:0]  vs1 = '0, vs2 = '0, mask = '0, vd_old = '0;
  logic [XLEN-1:0]  scal = '0;
  logic             busy, done;
  logic [VLEN-1:0]  vd;

  int n_chk = 0, n_fail = 0;

  always #5ns clk = ~clk;

  vadc_unit #(.VLEN(VLEN), .XLEN(XLEN)) i_vadc_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_i(sub), .scalar_sel_i(ssel),
    .sew_i(sew), .vl_i(vl), .vlmax_i(vlmax), .mlen_i(mlen), .vs1_i(vs1), .vs2_i(vs2),
    .scalar_i(scal), .mask_i(mask), .vd_i(vd_old), .busy_o(busy), .done_o(done), .vd_o(vd)
  );

  task automatic chk(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VLEN-1:0] model();
    logic [VLEN-1:0] r = vd_old;
    int esz = 1 << sew;
    for (int i = 0; i < int'(vlmax); i++) begin
      logic [63:0] a = '0, b = '0, y;
      logic c;
      int pos = i * int'(mlen);
      for (int j = 0; j < esz; j++) begin
        a[j*8 +: 8] = vs2[(i*esz + j)*8 +: 8];
        b[j*8 +: 8] = vs1[(i*esz + j)*8 +: 8];
      end
      if (ssel) b = {{(64-XLEN){scal[XLEN-1]}}, scal};
      c = (pos < VLEN) ? mask[pos] : 1'b0;
      y = sub ? a - b - 64'(c) : a + b + 64'(c);
      for (int j = 0; j < esz; j++)
        r[(i*esz + j)*8 +: 8] = (i < int'(vl)) ? y[j*8 +: 8] : 8'h00;
    end
    return r;
  endfunction

  task automatic run_case(input string tag, input bit poke);
    logic [VLEN-1:0] exp;
    int cnt = 0;
    @(negedge clk);
    exp = model();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 300) begin
      if (poke && cnt == 0) begin
        start = 1'b1; vs2 = ~vs2; vl = vlmax; sub = ~sub;
      end else start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk({tag, " result"}, vd, exp);
    chk("R9 latency", VLEN'(cnt), VLEN'(int'(vl_lat) + 1));
    @(negedge clk);
    chk("R9 pulse", VLEN'(done), '0);
  endtask

  // vl at start, kept apart since poke alters vl
  logic [IDX_W-1:0] vl_lat;

  task automatic setup(input bit s, input bit ss, input int w, input int l, input int lm, input int ml);
    sub = s; ssel = ss; sew = 2'(w); vl = IDX_W'(l); vlmax = IDX_W'(lm); mlen = 7'(ml);
    vl_lat = vl;
    vs1 = rnd_vec(); vs2 = rnd_vec(); mask = rnd_vec(); vd_old = rnd_vec(); scal = $urandom;
  endtask

  initial begin
    #2ms;
    n_fail++; n_chk++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R9 reset vd", vd, '0);
    chk("R9 reset flags", VLEN'({busy, done}), '0);
    rst_n = 1'b1;

    // R1 carry wraps at 8 bits
    setup(0, 0, 0, 4, 32, 1);
    vs2[7:0] = 8'hff; vs1[7:0] = 8'h00; mask[0] = 1'b1;
    run_case("R1", 0);
    // R2 borrow wraps at 16 bits
    setup(1, 0, 1, 5, 16, 1);
    vs2[15:0] = 16'h0; vs1[15:0] = 16'h0; mask = '1;
    run_case("R2", 0);
    // R3 wide elements
    setup(0, 0, 2, 8, 8, 4);  run_case("R3 sew32", 0);
    setup(1, 0, 3, 4, 4, 16); run_case("R3 sew64", 0);
    // R4 only stride points matter
    setup(0, 0, 0, 16, 32, 8);
    for (int k = 0; k < VLEN; k++) mask[k] = (k % 8) != 0;
    mask[16] = 1'b1;
    run_case("R4 stride", 0);
    setup(0, 0, 0, 32, 32, 64); run_case("R4 beyond mask", 0);
    // R5 sign extension before truncation
    setup(0, 1, 3, 4, 4, 16);
    scal = 32'hffff_ffff; mask = '0; vs2[63:0] = 64'd5;
    run_case("R5 neg scalar", 0);
    setup(1, 1, 1, 9, 16, 4); run_case("R5 sub scalar", 0);
    // R6 R7 tail and preserved bytes
    setup(0, 0, 1, 3, 10, 2);
    vd_old = '1;
    run_case("R6 R7 tail", 0);
    // R8 empty length
    setup(1, 0, 0, 0, 16, 2);
    vd_old = '1;
    run_case("R8 vl0", 0);
    // R10 start while busy
    setup(0, 0, 0, 6, 20, 1);
    run_case("R10 busy start", 1);

    for (int t = 0; t < 60; t++) begin
      int w = $urandom % 4;
      int lm = 1 + ($urandom % (NB >> w));
      int l = $urandom % (lm + 1);
      setup($urandom % 2, $urandom % 2, w, l, lm, 1 + $urandom % 64);
      run_case(sub ? "R2 R3 R4 R5 R6 rand" : "R1 R3 R4 R5 R7 rand", 0);
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule